// File: doc/BRIEF.md
# Load/Store Address and Data Unit

This block executes one memory-class micro-operation at a time for a segmented machine. It accepts a micro-operation together with its address operands, the old destination value and a set of qualifiers. It forms the effective address from a segment base, a scaled index, a base register and a displacement, and truncates the result to the operation's address size. For memory operations it then issues one request carrying a flag vector, and waits for the response.

When the operation finishes, the unit raises a one-cycle completion strobe. The strobe carries a fault indication, a writeback enable and the writeback value, formed at the operation's data size. Address-only operations (LEA) never reach memory and finish in the cycle after acceptance. Loads narrower than four bytes merge into the low bytes of the old destination. Loads of four bytes or more replace the destination and zero-extend it. A fault from memory suppresses the writeback, except that a prefetch swallows its fault silently.

Top module: `ldst_unit`

## Requirements
- R1: The request address equals (seg_base + scale*index + base + disp) truncated to the low asize*8 bits, where asize is 2, 4 or 8 bytes and scale is 1, 2, 4 or 8.
- R2: LEA (op code 5) computes scale*index + base + disp, ignores seg_base and issues no memory request. Its writeback appears on the completion strobe in the cycle after acceptance and follows the size rules of R3/R4.
- R3: A load (op codes 0, 1, 2) with dsize 1 or 2 writes back the old destination with only its low dsize bytes replaced by the response data.
- R4: A load with dsize 4 or 8 writes back the response data masked to dsize*8 bits, with all upper bits zero.
- R5: A response with fault set produces done_fault=1 and wb_en=0.
- R6: A load with prefetch set produces done_fault=0 and wb_en=0 on a faulting response, and sets request flag bit 5.
- R7: Request flags: op 1 sets bit 0 (store check); op 2 sets bits 0 and 1 (store check and lock); op 0 sets neither.
- R8: A store (op 3) and an unlocking store (op 4) drive mem_req_write=1 and wdata equal to the low dsize bytes of uop_data, with upper bits zero. Op 4 also sets flag bit 1 (lock).
- R9: Check-access (op 6) issues a write request with flag bit 2 (no-access) and wdata zero. No writeback follows.
- R10: uop_cpl0 sets flag bit 3, and uop_addr_legacy sets flag bit 4.
- R11: Only one operation is in flight at a time. uop_ready is low from acceptance until the completion cycle has passed, and a pending request holds its address until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uop_valid | input | 1 | Micro-operation offered |
| uop_ready | output | 1 | Unit idle, accepts micro-operation |
| uop_op | input | 3 | Operation code (0 load, 1 load+store-check, 2 locked load, 3 store, 4 unlocking store, 5 LEA, 6 check-access) |
| uop_dsize | input | 4 | Data size in bytes: 1, 2, 4, 8 |
| uop_asize | input | 4 | Address size in bytes: 2, 4, 8 |
| uop_seg_base | input | 64 | Segment base |
| uop_index | input | 64 | Index register value |
| uop_scale | input | 4 | Index scale: 1, 2, 4, 8 |
| uop_base | input | 64 | Base register value |
| uop_disp | input | 64 | Displacement |
| uop_data | input | 64 | Old destination (loads, LEA) or store source |
| uop_cpl0 | input | 1 | Privilege-0 access qualifier |
| uop_addr_legacy | input | 1 | Legacy address-size override qualifier |
| uop_prefetch | input | 1 | Prefetch qualifier (loads only) |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | 64 | Effective address |
| mem_req_write | output | 1 | Request is a write |
| mem_req_wdata | output | 64 | Write data |
| mem_req_size | output | 4 | Access size in bytes |
| mem_req_flags | output | 6 | Flags: 0 store check, 1 lock, 2 no-access, 3 cpl0, 4 addr-size override, 5 prefetch |
| mem_rsp_valid | input | 1 | Memory response offered |
| mem_rsp_ready | output | 1 | Unit waiting for response |
| mem_rsp_data | input | 64 | Response data |
| mem_rsp_fault | input | 1 | Response carries a fault |
| done_valid | output | 1 | One-cycle completion strobe |
| done_fault | output | 1 | Completion reports a fault |
| wb_en | output | 1 | Destination writeback enable |
| wb_data | output | 64 | Destination writeback value |

## Verification
An LEA finishes one cycle after it is accepted. For a memory operation, the request is up in the cycle after acceptance, and completion follows one cycle after the response handshake. The bench changes inputs only on falling edges. It samples the request at the first falling edge after acceptance, and samples the completion strobe at the falling edge after the response handshake, or the one after acceptance for LEA. At those same points it also checks that uop_ready is low and that no request is raised for LEA.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int FLAG_W   = 6;
  localparam int FL_STCHK = 0;
  localparam int FL_LOCK  = 1;
  localparam int FL_NOACC = 2;
  localparam int FL_CPL0  = 3;
  localparam int FL_ASZ   = 4;
  localparam int FL_PREF  = 5;

  typedef enum logic [2:0] {
    OP_LD    = 3'd0,
    OP_LDST  = 3'd1,
    OP_LDSTL = 3'd2,
    OP_ST    = 3'd3,
    OP_STUL  = 3'd4,
    OP_LEA   = 3'd5,
    OP_CDA   = 3'd6
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2,
    ST_DONE = 2'd3
  } state_e;

  function automatic logic is_load(input logic [2:0] op);
    return (op == OP_LD) || (op == OP_LDST) || (op == OP_LDSTL) || (op == 3'd7);
  endfunction
endpackage

// File: rtl/ldst_agen.sv
module ldst_agen #(
  parameter int AW = 64,
  parameter int SW = 4
) (
  input  logic [AW-1:0] seg_base,
  input  logic          use_seg,
  input  logic [AW-1:0] index,
  input  logic [SW-1:0] scale,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] disp,
  input  logic [SW-1:0] asize,
  output logic [AW-1:0] ea
);
  localparam int NB = AW / 8;

  logic [AW-1:0] sum;
  logic [AW-1:0] amask;

  always_comb begin
    sum = (use_seg ? seg_base : '0) + index * AW'(scale) + base + disp;
    amask = '0;
    for (int i = 0; i < NB; i++) begin
      if (i < int'(asize)) amask[i*8 +: 8] = 8'hFF;
    end
    ea = sum & amask;
  end
endmodule

// File: rtl/ldst_wbfmt.sv
module ldst_wbfmt #(
  parameter int DW = 64,
  parameter int SW = 4,
  parameter int MERGE_LIMIT = 4
) (
  input  logic [SW-1:0] dsize,
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] new_val,
  output logic [DW-1:0] result
);
  localparam int NB = DW / 8;

  logic [DW-1:0] dmask;

  always_comb begin
    dmask = '0;
    for (int i = 0; i < NB; i++) begin
      if (i < int'(dsize)) dmask[i*8 +: 8] = 8'hFF;
    end
    if (int'(dsize) < MERGE_LIMIT) result = (old_val & ~dmask) | (new_val & dmask);
    else                           result = new_val & dmask;
  end
endmodule

// File: rtl/ldst_reqfmt.sv
module ldst_reqfmt
  import ldst_pkg::*;
#(
  parameter int DW = 64,
  parameter int SW = 4
) (
  input  logic [2:0]        op,
  input  logic [SW-1:0]     dsize,
  input  logic [DW-1:0]     data,
  input  logic              cpl0,
  input  logic              addr_legacy,
  input  logic              prefetch,
  output logic [FLAG_W-1:0] flags,
  output logic              write,
  output logic [DW-1:0]     wdata
);
  localparam int NB = DW / 8;

  logic [DW-1:0] dmask;
  logic          ld;

  always_comb begin
    dmask = '0;
    for (int i = 0; i < NB; i++) begin
      if (i < int'(dsize)) dmask[i*8 +: 8] = 8'hFF;
    end
    ld    = is_load(op);
    flags = '0;
    flags[FL_STCHK] = (op == OP_LDST) || (op == OP_LDSTL);
    flags[FL_LOCK]  = (op == OP_LDSTL) || (op == OP_STUL);
    flags[FL_NOACC] = (op == OP_CDA);
    flags[FL_CPL0]  = cpl0;
    flags[FL_ASZ]   = addr_legacy;
    flags[FL_PREF]  = ld && prefetch;
    write = (op == OP_ST) || (op == OP_STUL) || (op == OP_CDA);
    wdata = (op == OP_CDA) ? '0 : (data & dmask);
  end
endmodule

// File: rtl/ldst_unit.sv
module ldst_unit
  import ldst_pkg::*;
#(
  parameter int AW = 64,
  parameter int DW = 64,
  parameter int SW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uop_valid,
  output logic              uop_ready,
  input  logic [2:0]        uop_op,
  input  logic [SW-1:0]     uop_dsize,
  input  logic [SW-1:0]     uop_asize,
  input  logic [AW-1:0]     uop_seg_base,
  input  logic [AW-1:0]     uop_index,
  input  logic [SW-1:0]     uop_scale,
  input  logic [AW-1:0]     uop_base,
  input  logic [AW-1:0]     uop_disp,
  input  logic [DW-1:0]     uop_data,
  input  logic              uop_cpl0,
  input  logic              uop_addr_legacy,
  input  logic              uop_prefetch,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  output logic              mem_req_write,
  output logic [DW-1:0]     mem_req_wdata,
  output logic [SW-1:0]     mem_req_size,
  output logic [FLAG_W-1:0] mem_req_flags,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DW-1:0]     mem_rsp_data,
  input  logic              mem_rsp_fault,
  output logic              done_valid,
  output logic              done_fault,
  output logic              wb_en,
  output logic [DW-1:0]     wb_data
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ni     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ni     <= rst_meta_q;
    end
  end

  state_e state_q, state_d;
  logic accept, req_fire, rsp_fire;
  logic [AW-1:0] ea_c;
  logic [FLAG_W-1:0] flags_c;
  logic write_c;
  logic [DW-1:0] wdata_c, fmt_old, fmt_new, fmt_res;

  logic [2:0]        op_q;
  logic [SW-1:0]     dsize_q, asize_q;
  logic [AW-1:0]     ea_q;
  logic [DW-1:0]     old_q, wdata_q, res_q;
  logic [FLAG_W-1:0] flags_q;
  logic              write_q, wben_q, fault_q;

  assign accept   = uop_valid && uop_ready;
  assign req_fire = mem_req_valid && mem_req_ready;
  assign rsp_fire = mem_rsp_valid && mem_rsp_ready;

  ldst_agen #(.AW(AW), .SW(SW)) u_agen (
    .seg_base(uop_seg_base), .use_seg(uop_op != OP_LEA), .index(uop_index),
    .scale(uop_scale), .base(uop_base), .disp(uop_disp), .asize(uop_asize),
    .ea(ea_c)
  );

  ldst_reqfmt #(.DW(DW), .SW(SW)) u_reqfmt (
    .op(uop_op), .dsize(uop_dsize), .data(uop_data), .cpl0(uop_cpl0),
    .addr_legacy(uop_addr_legacy), .prefetch(uop_prefetch),
    .flags(flags_c), .write(write_c), .wdata(wdata_c)
  );

  // one formatter shared: LEA at acceptance, loads at response
  assign fmt_old = (state_q == ST_IDLE) ? uop_data : old_q;
  assign fmt_new = (state_q == ST_IDLE) ? DW'(ea_c) : mem_rsp_data;

  ldst_wbfmt #(.DW(DW), .SW(SW)) u_wbfmt (
    .dsize((state_q == ST_IDLE) ? uop_dsize : dsize_q),
    .old_val(fmt_old), .new_val(fmt_new), .result(fmt_res)
  );

  // next-state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = (uop_op == OP_LEA) ? ST_DONE : ST_REQ;
      ST_REQ:  if (req_fire) state_d = ST_RSP;
      ST_RSP:  if (rsp_fire) state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // operand capture (clock enable: accept)
  always_ff @(posedge clk) begin
    if (accept) begin
      op_q    <= uop_op;
      dsize_q <= uop_dsize;
      asize_q <= uop_asize;
      ea_q    <= ea_c;
      old_q   <= uop_data;
      flags_q <= flags_c;
      write_q <= write_c;
      wdata_q <= wdata_c;
    end
  end

  // result capture (clock enable: LEA accept or response)
  always_ff @(posedge clk) begin
    if (accept && uop_op == OP_LEA) begin
      res_q   <= fmt_res;
      wben_q  <= 1'b1;
      fault_q <= 1'b0;
    end else if (rsp_fire) begin
      res_q   <= fmt_res;
      wben_q  <= is_load(op_q) && !mem_rsp_fault;
      fault_q <= mem_rsp_fault && !flags_q[FL_PREF];
    end
  end

  assign uop_ready     = (state_q == ST_IDLE) && rst_ni;
  assign mem_req_valid = (state_q == ST_REQ);
  assign mem_req_addr  = ea_q;
  assign mem_req_write = write_q;
  assign mem_req_wdata = wdata_q;
  assign mem_req_size  = dsize_q;
  assign mem_req_flags = flags_q;
  assign mem_rsp_ready = (state_q == ST_RSP);
  assign done_valid    = (state_q == ST_DONE);
  assign done_fault    = done_valid && fault_q;
  assign wb_en         = done_valid && wben_q;
  assign wb_data       = res_q;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R11
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    accept |=> !uop_ready);
  // R5
  fault_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    done_valid && done_fault |-> !wb_en);
  // R2
  lea_fast_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    accept && uop_op == OP_LEA |=> done_valid && !mem_req_valid);
  // R1
  addr_trunc_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req_valid && asize_q == SW'(2) |-> mem_req_addr[AW-1:16] == '0);
  // R9
  noacc_zero_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req_valid && mem_req_flags[FL_NOACC] |-> mem_req_wdata == '0);
endmodule

// File: tb/tb_ldst_unit.sv
module tb_ldst_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic uop_valid = 0, uop_ready;
  logic [2:0] uop_op = 0;
  logic [3:0] uop_dsize = 8, uop_asize = 8, uop_scale = 1;
  logic [63:0] uop_seg_base = 0, uop_index = 0, uop_base = 0, uop_disp = 0, uop_data = 0;
  logic uop_cpl0 = 0, uop_addr_legacy = 0, uop_prefetch = 0;
  logic mem_req_valid, mem_req_ready = 0, mem_req_write;
  logic [63:0] mem_req_addr, mem_req_wdata;
  logic [3:0] mem_req_size;
  logic [5:0] mem_req_flags;
  logic mem_rsp_valid = 0, mem_rsp_ready, mem_rsp_fault = 0;
  logic [63:0] mem_rsp_data = 0;
  logic done_valid, done_fault, wb_en;
  logic [63:0] wb_data;

  ldst_unit dut (.*);

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  // captured results
  logic g_req, g_busy, g_write, g_done, g_fault, g_wben;
  logic [63:0] g_addr, g_wdata, g_wb;
  logic [5:0] g_flags;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [3:0] ds, input logic [3:0] as,
                        input logic [63:0] seg, input logic [63:0] idx, input logic [3:0] sc,
                        input logic [63:0] bs, input logic [63:0] dp, input logic [63:0] dat,
                        input logic cp, input logic lg, input logic pf,
                        input logic [63:0] rdata, input logic rfault);
    @(negedge clk);
    uop_op = op; uop_dsize = ds; uop_asize = as; uop_seg_base = seg; uop_index = idx;
    uop_scale = sc; uop_base = bs; uop_disp = dp; uop_data = dat;
    uop_cpl0 = cp; uop_addr_legacy = lg; uop_prefetch = pf; uop_valid = 1;
    @(negedge clk);
    uop_valid = 0;
    g_req = mem_req_valid; g_busy = uop_ready;
    if (op == 3'd5) begin
      g_done = done_valid; g_fault = done_fault; g_wben = wb_en; g_wb = wb_data;
    end else begin
      g_addr = mem_req_addr; g_flags = mem_req_flags; g_write = mem_req_write;
      g_wdata = mem_req_wdata;
      mem_req_ready = 1;
      @(negedge clk);
      mem_req_ready = 0;
      mem_rsp_valid = 1; mem_rsp_data = rdata; mem_rsp_fault = rfault;
      @(negedge clk);
      mem_rsp_valid = 0; mem_rsp_fault = 0;
      g_done = done_valid; g_fault = done_fault; g_wben = wb_en; g_wb = wb_data;
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11 reset uop_ready", uop_ready, 1);
    chk("R11 reset req_valid", mem_req_valid, 0);
    chk("R11 reset done_valid", done_valid, 0);
  endtask

  task automatic t_load_narrow;
    run_op(3'd0, 2, 8, 64'h1000, 3, 4, 64'h100, 64'h20, 64'hAAAA_BBBB_CCCC_DDDD,
           0, 0, 0, 64'h1111_2222_3333_4444, 0);
    chk("R1 ea full", g_addr, 64'h112C);
    chk("R11 busy during req", g_busy, 0);
    chk("R7 plain load flags", g_flags, 6'h00);
    chk("R3 merge wb_en", g_wben, 1);
    chk("R3 merge data", g_wb, 64'hAAAA_BBBB_CCCC_4444);
    run_op(3'd0, 1, 4, 0, 0, 1, 64'h8, 0, 64'hFFFF_FFFF_FFFF_FFFF,
           0, 0, 0, 64'h5A5A_5A5A_5A5A_5A12, 0);
    chk("R3 merge byte", g_wb, 64'hFFFF_FFFF_FFFF_FF12);
  endtask

  task automatic t_load_wide;
    run_op(3'd0, 4, 2, 64'hFFFF0, 0, 1, 64'h20, 0, 64'hAAAA_BBBB_CCCC_DDDD,
           0, 0, 0, 64'h1111_2222_3333_4444, 0);
    chk("R1 ea truncated 16b", g_addr, 64'h0010);
    chk("R4 zero-extend 4B", g_wb, 64'h0000_0000_3333_4444);
    run_op(3'd0, 8, 4, 64'h8000_0000, 2, 8, 64'h8000_0000, 0, 0,
           0, 0, 0, 64'h0123_4567_89AB_CDEF, 0);
    chk("R1 ea truncated 32b", g_addr, 64'h10);
    chk("R4 full 8B", g_wb, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_flags;
    run_op(3'd1, 8, 8, 0, 0, 1, 64'h40, 0, 0, 1, 0, 0, 0, 0);
    chk("R7 R10 ldst+cpl0 flags", g_flags, 6'h09);
    chk("R7 ldst is read", g_write, 0);
    run_op(3'd2, 8, 8, 0, 0, 1, 64'h40, 0, 0, 0, 1, 0, 0, 0);
    chk("R7 R10 locked+legacy flags", g_flags, 6'h13);
  endtask

  task automatic t_fault;
    run_op(3'd0, 8, 8, 0, 0, 1, 64'h80, 0, 64'h1234, 0, 0, 0, 64'hDEAD, 1);
    chk("R5 fault done", g_done, 1);
    chk("R5 fault reported", g_fault, 1);
    chk("R5 fault no wb", g_wben, 0);
    run_op(3'd0, 8, 8, 0, 0, 1, 64'h80, 0, 64'h1234, 0, 0, 1, 64'hDEAD, 1);
    chk("R6 prefetch flag", g_flags, 6'h20);
    chk("R6 prefetch fault hidden", g_fault, 0);
    chk("R6 prefetch no wb", g_wben, 0);
  endtask

  task automatic t_store;
    run_op(3'd3, 1, 8, 0, 0, 1, 64'h200, 0, 64'h0102_0304_0506_07EF, 0, 0, 0, 0, 0);
    chk("R8 store write", g_write, 1);
    chk("R8 store wdata 1B", g_wdata, 64'hEF);
    chk("R8 store flags", g_flags, 6'h00);
    chk("R8 store no wb", g_wben, 0);
    run_op(3'd4, 2, 8, 0, 0, 1, 64'h200, 0, 64'h0102_0304_0506_BEEF, 0, 0, 0, 0, 0);
    chk("R8 unlock store flags", g_flags, 6'h02);
    chk("R8 unlock store wdata", g_wdata, 64'hBEEF);
  endtask

  task automatic t_cda;
    run_op(3'd6, 8, 8, 0, 0, 1, 64'h300, 0, 64'hFFFF_0000_FFFF_0000, 0, 0, 0, 0, 0);
    chk("R9 noacc flags", g_flags, 6'h04);
    chk("R9 noacc wdata zero", g_wdata, 0);
    chk("R9 noacc write", g_write, 1);
    chk("R9 noacc no wb", g_wben, 0);
  endtask

  task automatic t_lea;
    run_op(3'd5, 2, 8, 64'h5000, 2, 8, 64'h10, 1, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 0);
    chk("R2 lea no request", g_req, 0);
    chk("R2 lea done next cycle", g_done, 1);
    chk("R2 lea wb_en", g_wben, 1);
    chk("R2 lea merged result", g_wb, 64'hFFFF_FFFF_FFFF_0021);
    run_op(3'd5, 4, 8, 64'h5000, 0, 1, 64'hF_0000_0000, 64'h7, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 0);
    chk("R2 lea wide zero-extend", g_wb, 64'h7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_load_narrow();
    t_load_wide();
    t_flags();
    t_fault();
    t_store();
    t_cda();
    t_lea();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule